// File: doc/BRIEF.md
# ACPI SCI Event Combiner

This block holds the power-management event status and event enable registers for four event sources: timer overflow, global lock release, power button and real-time-clock alarm. Each source delivers a one-cycle pulse that latches its status bit. Software clears a status bit by writing a 1 to it. Software also programs the enable bits through the same 16-bit register port. The block drives a level-sensitive system control interrupt (SCI). The SCI is high while any source has both its status and its enable bit set.

SCI is suppressed whenever the function's interrupt-pin configuration value is zero. The block also drives a timer-arm output. This output tells an external overflow counter whether an overflow event should still be scheduled: it is high when the timer event is enabled and its status is not yet pending. The counter itself and the sleep-control register lie outside this block.

Top module: `pm_event_sci`

## Requirements
- R1: A one-cycle pulse on an event input sets its status bit at the next clock edge. The bit positions are: timer bit 0, global lock bit 5, power button bit 8, RTC alarm bit 10.
- R2: A status write (reg_sel_i = 0) clears every implemented status bit written as 1. Bits written as 0 keep their value.
- R3: If an event pulse arrives in the same cycle as a write-1 clear of its bit, the bit stays set.
- R4: An enable write (reg_sel_i = 1) loads bits 0, 5, 8 and 10 from the write data. All other bits of both registers always read 0.
- R5: reg_rdata_o shows the status register when reg_sel_i is 0 and the enable register when it is 1. It follows reg_sel_i in the same cycle.
- R6: sci_o is registered. It is high in the cycle after one in which irq_pin_i is nonzero and some event has both its status and its enable bit set. Otherwise it is low.
- R7: sci_o is low in the cycle after any cycle in which irq_pin_i is zero, whatever the status and enable bits hold.
- R8: tmr_arm_o is high exactly when the timer enable bit is set and the timer status bit is clear. A timer pulse therefore drops it after the next edge.
- R9: While rst_ni is low, both registers read 0, and sci_o and tmr_arm_o are low.
- R10: A status bit latches even when its enable bit is clear. Such a bit does not raise sci_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data of the selected register |
| evt_tmr_i | input | 1 | Timer overflow event pulse |
| evt_gbl_i | input | 1 | Global lock event pulse |
| evt_pwr_i | input | 1 | Power button event pulse |
| evt_rtc_i | input | 1 | RTC alarm event pulse |
| irq_pin_i | input | PIN_W | Interrupt-pin configuration value; zero disables SCI |
| sci_o | output | 1 | System control interrupt level |
| tmr_arm_o | output | 1 | Timer overflow scheduling request |

## Verification
The assertions check several properties on every cycle:
- every event pulse sets its status bit at the next edge, even when a clear of that bit arrives in the same cycle;
- a clear without a pulse empties the bit;
- enable writes load the written values;
- SCI rises one cycle after an enabled pending event, and stays low after any cycle with a zero pin value;
- a timer pulse disarms the timer.

The bench scenarios cover what needs a view of the whole register port:
- unimplemented bits reading as zero in both registers;
- the read multiplexer following the select line;
- status latching while its enable is off;
- an asynchronous reset in mid-run clearing state that had been set.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int NUM_EVT = 4;

  // event index -> bit position in the 16-bit status/enable layout
  function automatic int evt_pos(input int k);
    case (k)
      0:       return 0;   // timer
      1:       return 5;   // global lock
      2:       return 8;   // power button
      default: return 10;  // rtc alarm
    endcase
  endfunction
endpackage

// File: rtl/pm_sts_bank.sv
module pm_sts_bank #(
  parameter int NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] sts_o
);
  logic [NUM_EVT-1:0] sts_q;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
    // set has priority over write-1-clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[k] <= 1'b0;
      else         sts_q[k] <= evt_i[k] | (sts_q[k] & ~clr_i[k]);
    end

    // R1
    a_r1_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> sts_o[k]);
    // R2
    a_r2_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !evt_i[k]) |=> !sts_o[k]);
    // R3
    a_r3_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && evt_i[k]) |=> sts_o[k]);
    // R2: no event and no clear keeps the bit
    a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i[k] && !evt_i[k]) |=> $stable(sts_o[k]));
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/pm_en_bank.sv
module pm_en_bank #(
  parameter int NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] en_o
);
  logic [NUM_EVT-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  // R4
  a_r4_en_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (en_o == $past(wdata_i)));
  a_r4_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_o));
endmodule

// File: rtl/pm_sci_drv.sv
module pm_sci_drv #(
  parameter int NUM_EVT = 4,
  parameter int PIN_W   = 8,
  parameter int TMR_IDX = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] sts_i,
  input  logic [NUM_EVT-1:0] en_i,
  input  logic [PIN_W-1:0]   pin_i,
  output logic               sci_o,
  output logic               tmr_arm_o
);
  logic pin_present;
  logic sci_q;

  assign pin_present = |pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_q <= 1'b0;
    else         sci_q <= pin_present & (|(sts_i & en_i));
  end

  assign sci_o     = sci_q;
  assign tmr_arm_o = en_i[TMR_IDX] & ~sts_i[TMR_IDX];

  // R6
  a_r6_sci_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_present && (|(sts_i & en_i))) |=> sci_o);
  // R7
  a_r7_no_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_present |=> !sci_o);
  // R10
  a_r10_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_i & en_i) == '0) |=> !sci_o);
endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
  import pm_evt_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int PIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             evt_tmr_i,
  input  logic             evt_gbl_i,
  input  logic             evt_pwr_i,
  input  logic             evt_rtc_i,
  input  logic [PIN_W-1:0] irq_pin_i,
  output logic             sci_o,
  output logic             tmr_arm_o
);
  localparam int NE = NUM_EVT;

  logic [NE-1:0]    evt;
  logic [NE-1:0]    wdata_c;
  logic [NE-1:0]    clr;
  logic [NE-1:0]    sts_c;
  logic [NE-1:0]    en_c;
  logic [REG_W-1:0] sts_x;
  logic [REG_W-1:0] en_x;
  logic             unused_wdata;

  assign evt          = {evt_rtc_i, evt_pwr_i, evt_gbl_i, evt_tmr_i};
  assign unused_wdata = ^reg_wdata_i;

  for (genvar k = 0; k < NE; k++) begin : g_map
    assign wdata_c[k] = reg_wdata_i[evt_pos(k)];
  end

  assign clr = (reg_wr_i && !reg_sel_i) ? wdata_c : '0;

  pm_sts_bank #(.NUM_EVT(NE)) i_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (clr),
    .sts_o  (sts_c)
  );

  pm_en_bank #(.NUM_EVT(NE)) i_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_wr_i & reg_sel_i),
    .wdata_i (wdata_c),
    .en_o    (en_c)
  );

  pm_sci_drv #(.NUM_EVT(NE), .PIN_W(PIN_W), .TMR_IDX(0)) i_sci (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sts_i     (sts_c),
    .en_i      (en_c),
    .pin_i     (irq_pin_i),
    .sci_o     (sci_o),
    .tmr_arm_o (tmr_arm_o)
  );

  always_comb begin
    sts_x = '0;
    en_x  = '0;
    for (int k = 0; k < NE; k++) begin
      sts_x[evt_pos(k)] = sts_c[k];
      en_x[evt_pos(k)]  = en_c[k];
    end
  end

  assign reg_rdata_o = reg_sel_i ? en_x : sts_x;

  // R8
  a_r8_tmr_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_tmr_i |=> !tmr_arm_o);
  // R4: unimplemented bits never read back
  a_r4_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~16'h0521) == '0);
endmodule

// File: tb/test_pm_event_sci.sv
`timescale 1ns/1ps
module test_pm_event_sci;
  localparam logic [15:0] MASK = 16'h0521;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [3:0]  ev = '0;   // {rtc, pwr, gbl, tmr}
  logic [7:0]  pin = '0;
  logic [15:0] rdata;
  logic        sci, tmr_arm;

  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;
  string tag = "R9";

  // reference model state
  logic [15:0] m_sts = '0, m_en = '0;
  logic        m_sci = 1'b0;

  always #5 clk = ~clk;

  pm_event_sci i_pm_event_sci (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .evt_tmr_i(ev[0]), .evt_gbl_i(ev[1]), .evt_pwr_i(ev[2]), .evt_rtc_i(ev[3]),
    .irq_pin_i(pin), .sci_o(sci), .tmr_arm_o(tmr_arm)
  );

  function automatic logic [15:0] ev_bits(input logic [3:0] e);
    logic [15:0] r = '0;
    r[0] = e[0]; r[5] = e[1]; r[8] = e[2]; r[10] = e[3];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = '0; m_en = '0; m_sci = 1'b0;
    end else begin
      logic [15:0] clr_v;
      m_sci = (pin != 0) && ((m_sts & m_en & MASK) != 0);
      clr_v = (wr && !sel) ? (wdata & MASK) : '0;
      m_sts = ((m_sts & ~clr_v) | ev_bits(ev)) & MASK;
      if (wr && sel) m_en = wdata & MASK;
    end
  end

  task automatic compare();
    logic [15:0] exp_rd = sel ? m_en : m_sts;
    logic        exp_arm = m_en[0] & ~m_sts[0];
    vectors++;
    if (rdata !== exp_rd) begin
      errors++;
      $display("FAIL %s rdata sel=%0d got %h exp %h", tag, sel, rdata, exp_rd);
    end
    vectors++;
    if (sci !== m_sci) begin
      errors++;
      $display("FAIL %s sci got %b exp %b", tag, sci, m_sci);
    end
    vectors++;
    if (tmr_arm !== exp_arm) begin
      errors++;
      $display("FAIL %s tmr_arm got %b exp %b", tag, tmr_arm, exp_arm);
    end
  endtask

  // compare, then drive the next cycle's inputs
  task automatic step(input logic w, input logic s, input logic [15:0] d,
                      input logic [3:0] e, input logic [7:0] p);
    @(negedge clk);
    compare();
    wr = w; sel = s; wdata = d; ev = e; pin = p;
  endtask

  task automatic idle(input int n, input logic s);
    for (int i = 0; i < n; i++) step(1'b0, s, 16'h0, 4'h0, pin);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    // R9: reset state
    tag = "R9";
    pin = 8'h01;
    @(negedge clk); compare();
    @(negedge clk); compare();
    rst_n = 1'b1;
    idle(2, 1'b0);

    // R1 / R10: each event latches with enable clear, sci stays low
    tag = "R1 R10";
    for (int k = 0; k < 4; k++) begin
      step(1'b0, 1'b0, 16'h0, 4'(1 << k), 8'h01);
      idle(2, 1'b0);
    end
    step(1'b0, 1'b1, 16'h0, 4'h0, 8'h01);
    idle(1, 1'b0);

    // R2: write 0 has no effect, write 1 clears
    tag = "R2";
    step(1'b1, 1'b0, 16'h0000, 4'h0, 8'h01);
    idle(1, 1'b0);
    step(1'b1, 1'b0, 16'h0121, 4'h0, 8'h01);
    idle(1, 1'b0);
    step(1'b1, 1'b0, 16'hFFFF, 4'h0, 8'h01);
    idle(1, 1'b0);

    // R4 / R5: enable write, reserved bits read 0, read mux follows select
    tag = "R4 R5";
    step(1'b1, 1'b1, 16'hFFFF, 4'h0, 8'h01);
    idle(1, 1'b1);
    idle(1, 1'b0);
    step(1'b1, 1'b1, 16'hFADE, 4'h0, 8'h01);
    idle(1, 1'b1);
    step(1'b1, 1'b1, 16'h0521, 4'h0, 8'h01);
    idle(1, 1'b0);

    // R6 / R8: enabled event raises sci one cycle later, timer disarms
    tag = "R6 R8";
    step(1'b0, 1'b0, 16'h0, 4'b0001, 8'h01);
    idle(3, 1'b0);
    step(1'b1, 1'b0, 16'h0001, 4'h0, 8'h01);
    idle(2, 1'b0);
    step(1'b0, 1'b0, 16'h0, 4'b0100, 8'h80);
    idle(2, 1'b1);

    // R3: pulse coincides with clear
    tag = "R3";
    step(1'b1, 1'b0, 16'h0100, 4'b0100, 8'h80);
    idle(2, 1'b0);
    step(1'b1, 1'b0, 16'h0521, 4'b1000, 8'h80);
    idle(2, 1'b0);

    // R7: zero pin suppresses sci
    tag = "R7";
    step(1'b0, 1'b0, 16'h0, 4'h0, 8'h00);
    idle(3, 1'b0);
    step(1'b0, 1'b0, 16'h0, 4'h0, 8'h04);
    idle(2, 1'b0);

    // R9: mid-run reset with state set
    tag = "R9";
    @(negedge clk);
    rst_n = 1'b0;
    #1 compare();
    @(negedge clk); compare();
    wr = 1'b0; sel = 1'b1;
    @(negedge clk); compare();
    rst_n = 1'b1;
    idle(1, 1'b1);

    // mixed traffic: R1 R2 R3 R4 R5 R6 R7 R8 R10
    tag = "mixed R1 R2 R3 R6 R8";
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] r = $urandom;
      logic [3:0]  e = (r[3:0] & r[7:4]);
      logic [7:0]  p = r[8] ? 8'h00 : {4'h0, r[12:9] | 4'h1};
      if (r[20:18] == 3'd0) p = 8'h00;
      else if (!r[8]) p = {4'h0, r[12:9] | 4'h1};
      else p = 8'h02;
      step(r[13] & r[14], r[15], $urandom, e, p);
    end
    idle(2, 1'b0);
    finish_run();
  end
endmodule